// File: doc/BRIEF.md
# Non-Blocking Cache Miss Tracker

This block keeps a small table of outstanding cache-line misses for a data cache that keeps serving accesses while lines are fetched. A load that misses presents its line address and a requester tag on the lookup port. If no entry is waiting on that line, the block claims a free entry and sends one read request to memory, tagged with the entry index. If an entry is already waiting on that line, the load is added to that entry's target list and no memory request is made.

When memory returns a line, the fill port names the entry by its index. Fills may come back in any order. The entry then replays each stored requester tag on a valid/ready response port, one per cycle, oldest first. After the last tag is replayed, the entry is released. A prefetch port claims entries in the same way as demand misses but stores no requester. When no entry can take a request, the block holds its ready signal low so the cache stalls.

Top module: `missTracker`

## Requirements
- R1: After reset every entry is free. `lkReady` and `pfReady` are 1, and `rspValid` and `memReqValid` are 0.
- R2: An accepted lookup whose line is not waiting in any entry claims the lowest-numbered free entry. In the same cycle it asserts `memReqValid` with `memReqLine` equal to the lookup line and `memReqId` equal to that entry's index. A request id is never reused while its fill is outstanding.
- R3: A lookup whose line equals that of a waiting entry is accepted with no memory request and stored as an extra target of that entry. Each entry holds up to 4 targets.
- R4: A lookup that matches a waiting entry which already holds 4 targets sees `lkReady` low, and no request is made. This holds even when free entries exist.
- R5: When all 10 entries are taken (waiting or replaying) and a lookup or prefetch names a new line, `lkReady` (or `pfReady`) stays low and no request is made until an entry is released.
- R6: After the fill for an entry, its stored tags appear on `rspTag` in arrival order, one per accepted cycle (`rspValid && rspReady`). `rspLine` shows that entry's line. While `rspReady` is low, `rspValid`, `rspTag` and `rspLine` hold.
- R7: An entry is free for a new allocation in the cycle after its last response is accepted. An entry with no targets is free in the cycle after its fill.
- R8: A lookup in the same cycle as the fill of the entry holding its line does not join that entry. It claims a new entry and makes a new request.
- R9: A prefetch that names a new line claims an entry and makes a request but stores no target, so its fill produces no response. A prefetch to a line already waiting is accepted with no request. `pfReady` is 0 in any cycle where `lkValid` is 1.
- R10: A demand lookup that matches an entry claimed by a prefetch joins it as a normal target and gets exactly one response after the fill.
- R11: Fills are matched by id in any order. A fill whose id names an entry that is not waiting is ignored. When several entries are filled, they replay one entry at a time, and the lowest-numbered filled entry starts first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Demand miss present |
| lkLine | input | 26 | Line address of the miss (byte address bits above the 6 offset bits) |
| lkTag | input | 6 | Requester tag of the miss |
| lkReady | output | 1 | Miss accepted this cycle when valid |
| pfValid | input | 1 | Prefetch request present |
| pfLine | input | 26 | Line address to prefetch |
| pfReady | output | 1 | Prefetch accepted this cycle when valid |
| memReqValid | output | 1 | Read request to memory this cycle |
| memReqId | output | 4 | Entry index carried by the request |
| memReqLine | output | 26 | Line address of the request |
| fillValid | input | 1 | A line has returned from memory |
| fillId | input | 4 | Entry index of the returned line |
| rspValid | output | 1 | A stored requester is being replayed |
| rspReady | input | 1 | Consumer takes the replay this cycle |
| rspTag | output | 6 | Tag of the replayed requester |
| rspLine | output | 26 | Line address of the replayed requester |

## Verification
The tracker is driven with short directed sequences and with a long random mix. The directed sequences cover a new line (checks the allocation order), repeats of one line (merging apart from allocating), a fifth repeat (target capacity apart from table capacity), and a fill that coincides with a lookup to the same line (shows a releasing entry is never joined). Prefetch-only lines, a demand hit on a prefetched line, fills returned in reverse order with the response port stalled, and a completely full table each exercise a different accept rule. The random mix draws from a small pool of lines so that merges, full target lists and full tables happen often. Its fills land on waiting, replaying and free entries alike, which exposes any mismatch in the release timing.

// File: rtl/missTrackPkg.sv
package missTrackPkg;
  localparam int IDX_W = 8;
  typedef logic [IDX_W-1:0] idx_t;

  typedef enum logic [1:0] {ENT_FREE, ENT_WAIT, ENT_DRAIN} entState_t;

  typedef struct packed {
    logic alloc;
    logic allocDemand;
    idx_t allocIdx;
    logic merge;
    idx_t mergeIdx;
    idx_t mergeSlot;
    logic pop;
    idx_t popIdx;
  } ctlStrobe_t;
endpackage

// File: rtl/missCtl.sv
module missCtl
  import missTrackPkg::*;
#(
  parameter int N_ENT = 10,
  parameter int N_TGT = 4,
  localparam int CNT_W = $clog2(N_TGT + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             lkValid,
  input  logic             pfValid,
  input  logic [N_ENT-1:0] lkMatch,
  input  logic [N_ENT-1:0] pfMatch,
  input  logic             fillValid,
  input  idx_t             fillIdx,
  input  logic             rspReady,
  output ctlStrobe_t       stb,
  output logic             lkReady,
  output logic             pfReady,
  output logic             memReqValid,
  output logic             rspValid
);
  entState_t        entSt  [N_ENT];
  logic [CNT_W-1:0] entCnt [N_ENT];
  logic             busy;
  idx_t             busyIdx;

  logic [N_ENT-1:0] live, freeV, drainV, lkHitV, pfHitV;
  idx_t             freeIdx, hitIdx, drainIdx, actIdx;
  logic [CNT_W-1:0] hitCnt;
  logic             anyFree, anyDrain, lkHit, pfHit, hitFull, lastTgt;
  logic             lkAlloc, lkMerge, pfAlloc, popNow;

  for (genvar g = 0; g < N_ENT; g++) begin : gFlags
    assign freeV[g]  = (entSt[g] == ENT_FREE);
    assign drainV[g] = (entSt[g] == ENT_DRAIN);
    assign live[g]   = (entSt[g] == ENT_WAIT) && !(fillValid && fillIdx == idx_t'(g));
  end

  assign lkHitV = lkMatch & live;
  assign pfHitV = pfMatch & live;
  assign lkHit  = |lkHitV;
  assign pfHit  = |pfHitV;

  always_comb begin
    freeIdx  = '0;
    anyFree  = 1'b0;
    drainIdx = '0;
    anyDrain = 1'b0;
    hitIdx   = '0;
    hitCnt   = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (freeV[i]) begin
        freeIdx = idx_t'(i);
        anyFree = 1'b1;
      end
      if (drainV[i]) begin
        drainIdx = idx_t'(i);
        anyDrain = 1'b1;
      end
      if (lkHitV[i]) begin
        hitIdx = idx_t'(i);
        hitCnt = entCnt[i];
      end
    end
    actIdx  = busy ? busyIdx : drainIdx;
    lastTgt = 1'b0;
    for (int i = 0; i < N_ENT; i++)
      if (actIdx == idx_t'(i)) lastTgt = (entCnt[i] == CNT_W'(1));
  end

  assign hitFull     = (hitCnt == CNT_W'(N_TGT));
  assign lkReady     = lkHit ? !hitFull : anyFree;
  assign pfReady     = !lkValid && (pfHit || anyFree);
  assign lkAlloc     = lkValid && lkReady && !lkHit;
  assign lkMerge     = lkValid && lkReady && lkHit;
  assign pfAlloc     = pfValid && pfReady && !pfHit;
  assign memReqValid = lkAlloc || pfAlloc;
  assign rspValid    = busy || anyDrain;
  assign popNow      = rspValid && rspReady;

  always_comb begin
    stb.alloc       = lkAlloc || pfAlloc;
    stb.allocDemand = lkAlloc;
    stb.allocIdx    = freeIdx;
    stb.merge       = lkMerge;
    stb.mergeIdx    = hitIdx;
    stb.mergeSlot   = idx_t'(hitCnt);
    stb.pop         = popNow;
    stb.popIdx      = actIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_ENT; i++) begin
        entSt[i]  <= ENT_FREE;
        entCnt[i] <= '0;
      end
      busy    <= 1'b0;
      busyIdx <= '0;
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (stb.alloc && freeIdx == idx_t'(i)) begin
          entSt[i]  <= ENT_WAIT;
          entCnt[i] <= lkAlloc ? CNT_W'(1) : '0;
        end
        if (lkMerge && hitIdx == idx_t'(i))
          entCnt[i] <= entCnt[i] + CNT_W'(1);
        if (entSt[i] == ENT_WAIT && fillValid && fillIdx == idx_t'(i))
          entSt[i] <= (entCnt[i] == '0) ? ENT_FREE : ENT_DRAIN;
        if (popNow && actIdx == idx_t'(i)) begin
          entCnt[i] <= entCnt[i] - CNT_W'(1);
          if (entCnt[i] == CNT_W'(1)) entSt[i] <= ENT_FREE;
        end
      end
      busy <= rspValid && !(popNow && lastTgt);
      if (rspValid) busyIdx <= actIdx;
    end
  end
endmodule

// File: rtl/missData.sv
module missData
  import missTrackPkg::*;
#(
  parameter int LINE_W = 26,
  parameter int TAG_W  = 6,
  parameter int N_ENT  = 10,
  parameter int N_TGT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [LINE_W-1:0] lkLine,
  input  logic [LINE_W-1:0] pfLine,
  input  logic [TAG_W-1:0]  lkTag,
  output logic [N_ENT-1:0]  lkMatch,
  output logic [N_ENT-1:0]  pfMatch,
  output logic [LINE_W-1:0] reqLine,
  output logic [TAG_W-1:0]  rspTag,
  output logic [LINE_W-1:0] rspLine
);
  logic [LINE_W-1:0] lineReg [N_ENT];
  logic [TAG_W-1:0]  tgtReg  [N_ENT][N_TGT];

  assign reqLine = stb.allocDemand ? lkLine : pfLine;

  for (genvar g = 0; g < N_ENT; g++) begin : gCmp
    assign lkMatch[g] = (lineReg[g] == lkLine);
    assign pfMatch[g] = (lineReg[g] == pfLine);
  end

  always_comb begin
    rspTag  = '0;
    rspLine = '0;
    for (int i = 0; i < N_ENT; i++)
      if (stb.popIdx == idx_t'(i)) begin
        rspTag  = tgtReg[i][0];
        rspLine = lineReg[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < N_ENT; i++) begin
        lineReg[i] <= '0;
        for (int j = 0; j < N_TGT; j++) tgtReg[i][j] <= '0;
      end
    end else begin
      for (int i = 0; i < N_ENT; i++) begin
        if (stb.alloc && stb.allocIdx == idx_t'(i)) begin
          lineReg[i] <= reqLine;
          if (stb.allocDemand) tgtReg[i][0] <= lkTag;
        end
        if (stb.merge && stb.mergeIdx == idx_t'(i))
          for (int j = 0; j < N_TGT; j++)
            if (stb.mergeSlot == idx_t'(j)) tgtReg[i][j] <= lkTag;
        if (stb.pop && stb.popIdx == idx_t'(i))
          for (int j = 0; j < N_TGT - 1; j++) tgtReg[i][j] <= tgtReg[i][j+1];
      end
    end
  end
endmodule

// File: rtl/missTracker.sv
module missTracker
  import missTrackPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int TAG_W      = 6,
  parameter int N_ENT      = 10,
  parameter int N_TGT      = 4,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int LINE_W = ADDR_W - OFF_W,
  localparam int ID_W   = $clog2(N_ENT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lkValid,
  input  logic [LINE_W-1:0] lkLine,
  input  logic [TAG_W-1:0]  lkTag,
  output logic              lkReady,
  input  logic              pfValid,
  input  logic [LINE_W-1:0] pfLine,
  output logic              pfReady,
  output logic              memReqValid,
  output logic [ID_W-1:0]   memReqId,
  output logic [LINE_W-1:0] memReqLine,
  input  logic              fillValid,
  input  logic [ID_W-1:0]   fillId,
  output logic              rspValid,
  input  logic              rspReady,
  output logic [TAG_W-1:0]  rspTag,
  output logic [LINE_W-1:0] rspLine
);
  ctlStrobe_t       stb;
  logic [N_ENT-1:0] lkMatch, pfMatch;

  missCtl #(.N_ENT(N_ENT), .N_TGT(N_TGT)) uCtl (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .pfValid(pfValid),
    .lkMatch(lkMatch), .pfMatch(pfMatch), .fillValid(fillValid),
    .fillIdx(idx_t'(fillId)), .rspReady(rspReady), .stb(stb),
    .lkReady(lkReady), .pfReady(pfReady), .memReqValid(memReqValid),
    .rspValid(rspValid)
  );

  missData #(.LINE_W(LINE_W), .TAG_W(TAG_W), .N_ENT(N_ENT), .N_TGT(N_TGT)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .lkLine(lkLine), .pfLine(pfLine),
    .lkTag(lkTag), .lkMatch(lkMatch), .pfMatch(pfMatch), .reqLine(memReqLine),
    .rspTag(rspTag), .rspLine(rspLine)
  );

  assign memReqId = stb.allocIdx[ID_W-1:0];
endmodule

// File: rtl/missTrackerChk.sv
module missTrackerChk #(
  parameter int N_ENT  = 10,
  parameter int ID_W   = 4,
  parameter int TAG_W  = 6,
  parameter int LINE_W = 26
) (
  input logic              clk,
  input logic              rstN,
  input logic              lkValid,
  input logic              lkReady,
  input logic              pfValid,
  input logic              pfReady,
  input logic              memReqValid,
  input logic [ID_W-1:0]   memReqId,
  input logic              fillValid,
  input logic [ID_W-1:0]   fillId,
  input logic              rspValid,
  input logic              rspReady,
  input logic [TAG_W-1:0]  rspTag,
  input logic [LINE_W-1:0] rspLine
);
  logic [(1<<ID_W)-1:0] pendBit;

  always_ff @(posedge clk) begin
    if (!rstN) pendBit <= '0;
    else begin
      if (fillValid && !(memReqValid && memReqId == fillId)) pendBit[fillId] <= 1'b0;
      if (memReqValid) pendBit[memReqId] <= 1'b1;
    end
  end

  assert_unique_id_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !pendBit[memReqId]);

  assert_req_source_R2: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> ((lkValid && lkReady) || (pfValid && pfReady)));

  assert_stall_no_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && !lkReady) |-> !memReqValid);

  assert_rsp_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && !rspReady) |=> (rspValid && $stable(rspTag) && $stable(rspLine)));

  assert_pf_yield_R9: assert property (@(posedge clk) disable iff (!rstN)
    lkValid |-> !pfReady);
endmodule

bind missTracker missTrackerChk #(.N_ENT(N_ENT), .ID_W(ID_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) uChk (
  .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkReady(lkReady), .pfValid(pfValid),
  .pfReady(pfReady), .memReqValid(memReqValid), .memReqId(memReqId),
  .fillValid(fillValid), .fillId(fillId), .rspValid(rspValid), .rspReady(rspReady),
  .rspTag(rspTag), .rspLine(rspLine)
);

// File: tb/sim_missTracker.sv
module sim_missTracker;
  localparam int NE = 10, NT = 4, LW = 26, TW = 6, IW = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic lkValid = 0, pfValid = 0, fillValid = 0, rspReady = 0;
  logic [LW-1:0] lkLine = '0, pfLine = '0;
  logic [TW-1:0] lkTag = '0;
  logic [IW-1:0] fillId = '0;
  logic lkReady, pfReady, memReqValid, rspValid;
  logic [IW-1:0] memReqId;
  logic [LW-1:0] memReqLine, rspLine;
  logic [TW-1:0] rspTag;

  always #4 clk = ~clk;

  missTracker u0 (.*);

  int nChecks = 0, nFail = 0;
  bit done = 0;
  string curReq = "R1";

  int     mSt [NE];
  longint mLine [NE];
  int     mQ [NE][$];
  bit     mBusy = 0;
  int     mBusyIdx = 0;

  task automatic check(string req, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    lkValid = 0; pfValid = 0; fillValid = 0;
  endtask

  // one cycle: compare against the model, cross the edge, update the model
  task automatic cyc();
    int hit, pfHit, freeI, act;
    bit eLk, ePf, eMem, eRsp;
    #1;
    hit = -1; pfHit = -1; freeI = -1; act = -1;
    for (int i = NE - 1; i >= 0; i--) begin
      bit filling = fillValid && (int'(fillId) == i);
      if (mSt[i] == 1 && !filling && mLine[i] == longint'(lkLine)) hit = i;
      if (mSt[i] == 1 && !filling && mLine[i] == longint'(pfLine)) pfHit = i;
      if (mSt[i] == 0) freeI = i;
      if (mSt[i] == 2) act = i;
    end
    if (mBusy) act = mBusyIdx;
    eLk  = (hit >= 0) ? (mQ[hit].size() < NT) : (freeI >= 0);
    ePf  = !lkValid && (pfHit >= 0 || freeI >= 0);
    eMem = (lkValid && eLk && hit < 0) || (pfValid && ePf && pfHit < 0);
    eRsp = (act >= 0);
    check(curReq, "lkReady", lkReady, eLk);
    check(curReq, "pfReady", pfReady, ePf);
    check(curReq, "memReqValid", memReqValid, eMem);
    if (eMem) begin
      check(curReq, "memReqId", memReqId, freeI);
      check(curReq, "memReqLine", memReqLine, lkValid ? lkLine : pfLine);
    end
    check(curReq, "rspValid", rspValid, eRsp);
    if (eRsp) begin
      check(curReq, "rspTag", rspTag, mQ[act][0]);
      check(curReq, "rspLine", rspLine, mLine[act]);
    end
    @(posedge clk);
    if (eRsp) begin
      if (rspReady) begin
        void'(mQ[act].pop_front());
        if (mQ[act].size() == 0) begin mSt[act] = 0; mBusy = 0; end
        else begin mBusy = 1; mBusyIdx = act; end
      end else begin mBusy = 1; mBusyIdx = act; end
    end
    if (fillValid && int'(fillId) < NE && mSt[fillId] == 1)
      mSt[fillId] = (mQ[fillId].size() == 0) ? 0 : 2;
    if (eMem) begin
      mSt[freeI] = 1;
      mLine[freeI] = lkValid ? longint'(lkLine) : longint'(pfLine);
      mQ[freeI].delete();
      if (lkValid) mQ[freeI].push_back(int'(lkTag));
    end else if (lkValid && eLk && hit >= 0) mQ[hit].push_back(int'(lkTag));
    @(negedge clk);
  endtask

  task automatic lk(int line, int tag);
    lkValid = 1; lkLine = LW'(line); lkTag = TW'(tag);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    int c = 0;
    while (c < 100000) begin @(posedge clk); c++; end
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", c, 0);
    finishRun();
  end

  initial begin
    for (int i = 0; i < NE; i++) begin mSt[i] = 0; mLine[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    check("R1", "lkReady", lkReady, 1);
    check("R1", "pfReady", pfReady, 1);
    check("R1", "rspValid", rspValid, 0);
    check("R1", "memReqValid", memReqValid, 0);
    @(negedge clk);

    // R2 new lines claim lowest free entries
    curReq = "R2";
    lk('h100, 1); #1;
    check("R2", "memReqValid", memReqValid, 1);
    check("R2", "memReqId", memReqId, 0);
    check("R2", "memReqLine", memReqLine, 'h100);
    cyc();
    lk('h200, 2); #1;
    check("R2", "memReqId", memReqId, 1);
    cyc();

    // R3 merges without request
    curReq = "R3";
    for (int t = 3; t <= 5; t++) begin
      lk('h100, t); #1;
      check("R3", "memReqValid", memReqValid, 0);
      check("R3", "lkReady", lkReady, 1);
      cyc();
    end
    // R4 fifth target to a full entry stalls
    curReq = "R4";
    lk('h100, 6); #1;
    check("R4", "lkReady", lkReady, 0);
    cyc(); idle();

    // R11 out-of-order fill, R6 ordered replay with backpressure
    curReq = "R11";
    fillValid = 1; fillId = 1; rspReady = 1;
    cyc(); idle(); #1;
    check("R11", "rspTag", rspTag, 2);
    cyc();
    curReq = "R6";
    fillValid = 1; fillId = 0; rspReady = 0;
    cyc(); idle();
    cyc(); #1;
    check("R6", "rspTag held", rspTag, 1);
    cyc();
    rspReady = 1;
    repeat (4) cyc();
    #1;
    check("R6", "rspValid drained", rspValid, 0);
    curReq = "R7";
    lk('h300, 7); #1;
    check("R7", "memReqId", memReqId, 0);
    cyc();

    // R8 lookup racing the fill of its own line
    curReq = "R8";
    lk('h300, 8); fillValid = 1; fillId = 0; #1;
    check("R8", "memReqValid", memReqValid, 1);
    check("R8", "memReqId", memReqId, 1);
    cyc(); idle();
    cyc();
    fillValid = 1; fillId = 1;
    cyc(); idle();
    repeat (3) cyc();

    // R9 prefetch behaviour
    curReq = "R9";
    pfValid = 1; pfLine = 'h400; #1;
    check("R9", "memReqId", memReqId, 0);
    cyc();
    #1;
    check("R9", "memReqValid repeat pf", memReqValid, 0);
    check("R9", "pfReady repeat pf", pfReady, 1);
    cyc();
    pfLine = 'h600; lk('h500, 10); #1;
    check("R9", "pfReady with lookup", pfReady, 0);
    cyc(); idle();
    fillValid = 1; fillId = 0;
    cyc(); idle(); #1;
    check("R9", "rspValid pf only", rspValid, 0);
    cyc();
    pfValid = 1; pfLine = 'h700; #1;
    check("R9", "memReqId reuse", memReqId, 0);
    cyc(); idle();

    // R10 demand joins a prefetched entry
    curReq = "R10";
    pfValid = 1; pfLine = 'h800; #1;
    check("R10", "memReqId", memReqId, 2);
    cyc(); idle();
    lk('h800, 9); #1;
    check("R10", "memReqValid", memReqValid, 0);
    cyc(); idle();
    fillValid = 1; fillId = 2;
    cyc(); idle(); #1;
    check("R10", "rspTag", rspTag, 9);
    check("R10", "rspLine", rspLine, 'h800);
    cyc(); #1;
    check("R10", "single response", rspValid, 0);
    fillValid = 1; fillId = 0; cyc();
    fillId = 1; cyc(); idle();
    repeat (3) cyc();

    // R5 full table
    curReq = "R5";
    for (int i = 0; i < NE; i++) begin lk('h1000 + i, i); cyc(); end
    lk('h2000, 33); #1;
    check("R5", "lkReady full", lkReady, 0);
    check("R5", "memReqValid full", memReqValid, 0);
    cyc();
    idle(); pfValid = 1; pfLine = 'h2100; #1;
    check("R5", "pfReady full", pfReady, 0);
    cyc(); idle();
    lk('h2000, 33); fillValid = 1; fillId = 3;
    cyc(); fillValid = 0; #1;
    check("R7", "lkReady while replaying", lkReady, 0);
    check("R7", "rspTag", rspTag, 3);
    cyc(); #1;
    check("R7", "memReqId freed", memReqId, 3);
    cyc(); idle();

    // random mix
    curReq = "R11";
    for (int n = 0; n < 4000; n++) begin
      lkValid = ($urandom_range(1, 0) == 1);
      lkLine = LW'('h3000 + $urandom_range(11, 0));
      lkTag = TW'($urandom_range(63, 0));
      pfValid = ($urandom_range(4, 0) == 0);
      pfLine = LW'('h3000 + $urandom_range(11, 0));
      fillValid = ($urandom_range(2, 0) == 0);
      fillId = IW'($urandom_range(NE - 1, 0));
      rspReady = ($urandom_range(3, 0) != 0);
      cyc();
    end
    idle();
    finishRun();
  end
endmodule